// File: doc/BRIEF.md
# Octal DDR Pseudo-SRAM Transaction Controller

This block is the host side of a pseudo-SRAM attached over an 8-bit double-data-rate bus. That bus has an active-low chip select, a bus clock, an 8-bit data lane and a bidirectional data strobe. A simple request port takes one transaction at a time. A request carries the direction, the space (memory array or device registers), the burst kind (linear or wrapped), a word address and a word count. The block then drives the complete bus sequence:

- chip select low, with the clock running;
- the six command/address bytes;
- the latency wait;
- the data transfer;
- clock stopped and chip select high.

The controller runs on a system clock at twice the bus clock rate. Each system cycle is one half of a bus clock and carries exactly one byte. The 90- and 270-degree phase shifts are left to the IO layer around the block. The latency is chosen per transaction from the strobe level the device presents during the command/address bytes. Write data leaves as a high byte and then a low byte, with the strobe acting as a per-byte keep mask. Read bytes are taken on each strobe transition and paired into 16-bit words. Requests that are empty, too long for the device's refresh budget, or that run past the top of the address space are refused with a one-cycle error pulse.

Top module: `psram_ctrl`

## Requirements
- R1: After a request is accepted, chip select goes low and six bytes follow, one per half bus cycle, most significant first, from a 48-bit word. That word holds: bit 47 = 1 for read; bit 46 = 1 for register space; bit 45 = 1 for linear burst; bits 44:16 = word address bits AW-1:3 (zero-extended); bits 2:0 = word address bits 2:0. All other bits are zero.
- R2: Take Leff as the effective latency count and m as the multiplier. m = 2 when the sampled strobe is high during the last command/address half-cycle or when `cfg_force_dbl` is set; otherwise m = 1. For memory accesses and register reads, the first data half-cycle comes exactly 2·Leff·m half-cycles after the last command/address half-cycle.
- R3: The effective latency count is `cfg_lat`, raised to LAT_MIN when `cfg_lat` is smaller.
- R4: A register write sends its data in the half-cycle right after the command/address bytes, with no latency wait, and does not drive the strobe.
- R5: Each written word goes out as bits 15:8 and then bits 7:0, and `wr_take` pulses on the high-byte half-cycle. During memory writes the strobe is driven with the inverted byte enable, so a 1 means the device keeps that byte.
- R6: During a read, each change of the incoming strobe captures one byte, high byte first. Each completed pair gives one `rd_valid` pulse with the 16-bit word. Exactly the requested number of words is returned, in order.
- R7: A request with length 0, length above `cfg_max_words`, or address plus length above 2^AW is refused. `req_err` pulses for one cycle and chip select stays high.
- R8: During the latency wait and the read data phase, neither the data lane nor the strobe is driven by the host.
- R9: After the last data item, the clock is held low, chip select rises and `xfer_done` pulses in that same cycle. Chip select then stays high for at least 2·CSH_CLK half-cycles before the next transaction.
- R10: The bus clock is low in the first command/address half-cycle and toggles every half-cycle while chip select is low. It is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, two per bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_lat | input | LAT_W | Latency count in bus clocks |
| cfg_force_dbl | input | 1 | Always use doubled latency |
| cfg_max_words | input | CW | Longest accepted request in words |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_reg | input | 1 | 1 = register space |
| req_linear | input | 1 | 1 = linear burst, 0 = wrapped |
| req_addr | input | AW | Starting word address |
| req_len | input | CW | Word count |
| wr_data | input | 16 | Current write word |
| wr_be | input | 2 | Byte enables of current write word |
| wr_take | output | 1 | Current write word consumed; present next after the following cycle |
| rd_data | output | 16 | Read word |
| rd_valid | output | 1 | Read word valid |
| req_err | output | 1 | Request refused |
| xfer_done | output | 1 | Transaction finished |
| psr_cs_n | output | 1 | Bus chip select, active low |
| psr_ck | output | 1 | Bus clock |
| psr_dq_o | output | 8 | Data lane out |
| psr_dq_oe | output | 1 | Data lane output enable |
| psr_dq_i | input | 8 | Data lane in |
| psr_rwds_o | output | 1 | Strobe out (write mask) |
| psr_rwds_oe | output | 1 | Strobe output enable |
| psr_rwds_i | input | 1 | Strobe in (latency flag, read timing) |

## Verification
The bench sweeps several latency settings, including values below the floor. Each is tried with the strobe flag low and high, and with and without forced doubling. Every combination does a memory write followed by a read-back at a distinct address and length. The arrival of the first data half-cycle separates single from doubled latency, and separates clamped from raw counts. The written byte-enable patterns step through all four values. Because the model memory applies only the bytes the strobe leaves unmasked, a wrong mask polarity or a swapped byte order shows up as a read-back miscompare. Further cases cover:

- register writes, which must skip latency and leave the strobe undriven;
- wrapped reads, which clear the burst bit;
- requests that hit the length and address ceilings exactly;
- requests that exceed those ceilings by one, which must be refused.

// File: rtl/psram_pkg.sv
package psram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CA,
      ST_LAT,
      ST_WR,
      ST_RD,
      ST_END,
      ST_GAP
   } psram_st_t;

   localparam int CA_BYTES = 6;
   localparam int CA_BITS  = 8 * CA_BYTES;

endpackage

// File: rtl/psram_ca_enc.sv
module psram_ca_enc #(
   parameter int AW = 22
) (
   input  logic          is_rd,
   input  logic          is_reg,
   input  logic          is_lin,
   input  logic [AW-1:0] addr,
   input  logic [2:0]    idx,
   output logic [7:0]    byte_o
);
   import psram_pkg::*;

   localparam int UPW = 29;

   logic [CA_BITS-1:0] ca;

   assign ca = {is_rd, is_reg, is_lin, UPW'(addr[AW-1:3]), 13'd0, addr[2:0]};

   always_comb begin
      byte_o = 8'h00;
      for (int i = 0; i < CA_BYTES; i++) begin
         if (idx == 3'(i)) byte_o = ca[CA_BITS-1-8*i -: 8];
      end
   end

endmodule

// File: rtl/psram_lat_calc.sv
module psram_lat_calc #(
   parameter int LAT_W   = 4,
   parameter int LAT_MIN = 3,
   parameter int CNTW    = 10
) (
   input  logic [LAT_W-1:0] cfg_lat,
   input  logic             dbl,
   output logic [CNTW-1:0]  half_cycles
);
   localparam logic [LAT_W-1:0] FLOOR = LAT_W'(LAT_MIN);

   if (LAT_MIN < 1 || LAT_MIN >= (1 << LAT_W)) begin : g_bad_floor
      $error("psram_lat_calc: LAT_MIN must fit in LAT_W and be at least 1");
   end
   if (CNTW < LAT_W + 2) begin : g_bad_cntw
      $error("psram_lat_calc: CNTW too narrow for doubled latency");
   end

   logic [LAT_W-1:0] eff;

   assign eff         = (cfg_lat < FLOOR) ? FLOOR : cfg_lat;
   assign half_cycles = dbl ? (CNTW'(eff) << 2) : (CNTW'(eff) << 1);

endmodule

// File: rtl/psram_rd_cap.sv
module psram_rd_cap (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        en,
   input  logic        rwds_i,
   input  logic [7:0]  dq_i,
   output logic [15:0] word_o,
   output logic        valid_o
);
   logic       rwds_q;
   logic       half_q;
   logic [7:0] hi_q;
   logic       edge_seen;

   assign edge_seen = en && (rwds_i != rwds_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rwds_q  <= 1'b0;
         half_q  <= 1'b0;
         hi_q    <= 8'h00;
         word_o  <= 16'h0000;
         valid_o <= 1'b0;
      end else begin
         rwds_q  <= rwds_i;
         valid_o <= 1'b0;
         if (!en) begin
            half_q <= 1'b0;
         end else if (edge_seen) begin
            if (!half_q) begin
               hi_q   <= dq_i;
               half_q <= 1'b1;
            end else begin
               word_o  <= {hi_q, dq_i};
               valid_o <= 1'b1;
               half_q  <= 1'b0;
            end
         end
      end
   end

   AST_RD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o) else $error("AST_RD_SPACING"); // R6

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
   import psram_pkg::*;
#(
   parameter int AW      = 22,
   parameter int CW      = 9,
   parameter int LAT_W   = 4,
   parameter int LAT_MIN = 3,
   parameter int CSH_CLK = 2,
   parameter bit MASK_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LAT_W-1:0] cfg_lat,
   input  logic             cfg_force_dbl,
   input  logic [CW-1:0]    cfg_max_words,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_read,
   input  logic             req_reg,
   input  logic             req_linear,
   input  logic [AW-1:0]    req_addr,
   input  logic [CW-1:0]    req_len,
   input  logic [15:0]      wr_data,
   input  logic [1:0]       wr_be,
   output logic             wr_take,
   output logic [15:0]      rd_data,
   output logic             rd_valid,
   output logic             req_err,
   output logic             xfer_done,
   output logic             psr_cs_n,
   output logic             psr_ck,
   output logic [7:0]       psr_dq_o,
   output logic             psr_dq_oe,
   input  logic [7:0]       psr_dq_i,
   output logic             psr_rwds_o,
   output logic             psr_rwds_oe,
   input  logic             psr_rwds_i
);
   localparam int CNTW = (CW + 1 > LAT_W + 3) ? CW + 1 : LAT_W + 3;
   localparam int SW   = ((AW > CW) ? AW : CW) + 1;
   localparam int GAPN = 2 * CSH_CLK;
   localparam int HRW  = $clog2(GAPN + 1) + 1;

   if (AW < 4 || AW > 32) begin : g_bad_aw
      $error("psram_ctrl: AW must lie in 4..32");
   end
   if (CW < 1) begin : g_bad_cw
      $error("psram_ctrl: CW must be positive");
   end
   if (CSH_CLK < 1) begin : g_bad_csh
      $error("psram_ctrl: CSH_CLK must be positive");
   end

   psram_st_t       st_q;
   logic [CNTW-1:0] cnt_q;
   logic            rd_q, rg_q, lin_q;
   logic [AW-1:0]   addr_q;
   logic [CW-1:0]   len_q;
   logic [CW-1:0]   rx_q;
   logic [CNTW-1:0] lat_q;
   logic [7:0]      lo_q;
   logic            mlo_q;
   logic            err_q;
   logic            ph_q;
   logic            active;
   logic            bad_req;
   logic [1:0]      wmask;
   logic [7:0]      ca_byte;
   logic [CNTW-1:0] lat_cyc;
   logic            cap_valid;
   logic [15:0]     cap_word;
   logic [SW-1:0]   end_addr;

   // Write mask variant: byte-enable driven strobe or all bytes written
   if (MASK_EN) begin : g_mask
      assign wmask = ~wr_be;
   end else begin : g_nomask
      logic [1:0] be_unused;
      assign be_unused = wr_be;
      assign wmask     = 2'b00;
   end

   psram_ca_enc #(.AW(AW)) i_ca_enc (
      .is_rd  (rd_q),
      .is_reg (rg_q),
      .is_lin (lin_q),
      .addr   (addr_q),
      .idx    (cnt_q[2:0]),
      .byte_o (ca_byte)
   );

   psram_lat_calc #(.LAT_W(LAT_W), .LAT_MIN(LAT_MIN), .CNTW(CNTW)) i_lat_calc (
      .cfg_lat     (cfg_lat),
      .dbl         (psr_rwds_i | cfg_force_dbl),
      .half_cycles (lat_cyc)
   );

   psram_rd_cap i_rd_cap (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (st_q == ST_RD),
      .rwds_i  (psr_rwds_i),
      .dq_i    (psr_dq_i),
      .word_o  (cap_word),
      .valid_o (cap_valid)
   );

   assign end_addr = SW'(req_addr) + SW'(req_len);
   assign bad_req  = (req_len == '0) || (req_len > cfg_max_words) ||
                     (end_addr > (SW'(1) << AW));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         rd_q   <= 1'b0;
         rg_q   <= 1'b0;
         lin_q  <= 1'b0;
         addr_q <= '0;
         len_q  <= '0;
         rx_q   <= '0;
         lat_q  <= '0;
         lo_q   <= 8'h00;
         mlo_q  <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (bad_req) begin
                     err_q <= 1'b1;
                  end else begin
                     rd_q   <= req_read;
                     rg_q   <= req_reg;
                     lin_q  <= req_linear;
                     addr_q <= req_addr;
                     len_q  <= req_len;
                     rx_q   <= '0;
                     cnt_q  <= '0;
                     st_q   <= ST_CA;
                  end
               end
            end
            ST_CA: begin
               if (cnt_q == CNTW'(CA_BYTES - 1)) begin
                  cnt_q <= '0;
                  lat_q <= lat_cyc;
                  st_q  <= (rg_q && !rd_q) ? ST_WR : ST_LAT;
               end else begin
                  cnt_q <= cnt_q + CNTW'(1);
               end
            end
            ST_LAT: begin
               if (cnt_q == lat_q - CNTW'(1)) begin
                  cnt_q <= '0;
                  st_q  <= rd_q ? ST_RD : ST_WR;
               end else begin
                  cnt_q <= cnt_q + CNTW'(1);
               end
            end
            ST_WR: begin
               if (!cnt_q[0]) begin
                  lo_q  <= wr_data[7:0];
                  mlo_q <= wmask[0];
               end
               if (cnt_q == (CNTW'(len_q) << 1) - CNTW'(1)) begin
                  st_q <= ST_END;
               end
               cnt_q <= cnt_q + CNTW'(1);
            end
            ST_RD: begin
               if (cap_valid) begin
                  rx_q <= rx_q + CW'(1);
                  if (rx_q == len_q - CW'(1)) st_q <= ST_END;
               end
            end
            ST_END: begin
               cnt_q <= '0;
               st_q  <= ST_GAP;
            end
            ST_GAP: begin
               if (cnt_q == CNTW'(GAPN - 2)) st_q <= ST_IDLE;
               cnt_q <= cnt_q + CNTW'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign active = (st_q == ST_CA) || (st_q == ST_LAT) || (st_q == ST_WR) || (st_q == ST_RD);

   // Bus clock phase: low on the first command half-cycle, toggling while active
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ph_q <= 1'b0;
      else if (active) ph_q <= ~ph_q;
      else             ph_q <= 1'b0;
   end

   assign psr_cs_n    = ~active;
   assign psr_ck      = active & ph_q;
   assign psr_dq_oe   = (st_q == ST_CA) || (st_q == ST_WR);
   assign psr_rwds_oe = (st_q == ST_WR) && !rg_q;
   assign wr_take     = (st_q == ST_WR) && !cnt_q[0];

   always_comb begin
      psr_dq_o = 8'h00;
      if (st_q == ST_CA)      psr_dq_o = ca_byte;
      else if (st_q == ST_WR) psr_dq_o = cnt_q[0] ? lo_q : wr_data[15:8];
   end

   assign psr_rwds_o = psr_rwds_oe ? (cnt_q[0] ? mlo_q : wmask[1]) : 1'b0;
   assign req_ready  = (st_q == ST_IDLE);
   assign req_err    = err_q;
   assign xfer_done  = (st_q == ST_END);
   assign rd_data    = cap_word;
   assign rd_valid   = cap_valid;

   // Chip-select high run length, saturating, for the gap check
   logic [HRW-1:0] hi_run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      hi_run_q <= HRW'(GAPN);
      else if (!psr_cs_n)              hi_run_q <= '0;
      else if (hi_run_q != HRW'(GAPN)) hi_run_q <= hi_run_q + HRW'(1);
   end

   AST_CS_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(psr_cs_n) |-> (hi_run_q == HRW'(GAPN))) else $error("AST_CS_GAP"); // R9
   AST_CK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!psr_cs_n && !$past(psr_cs_n)) |-> (psr_ck != $past(psr_ck))) else $error("AST_CK_TOGGLE"); // R10
   AST_CK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      psr_cs_n |-> !psr_ck) else $error("AST_CK_PARKED"); // R10
   AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (!psr_dq_oe && !psr_rwds_oe)) else $error("AST_RD_NO_DRIVE"); // R8
   AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      req_err |-> (psr_cs_n && !psr_dq_oe)) else $error("AST_ERR_NO_BUS"); // R7
   AST_DONE_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |-> (psr_cs_n && !psr_ck && $past(!psr_cs_n))) else $error("AST_DONE_PARKED"); // R9
   AST_TAKE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_take |-> (psr_dq_oe && !psr_cs_n)) else $error("AST_TAKE_DRIVES"); // R5
   AST_CA_START: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(psr_cs_n) |-> psr_dq_oe) else $error("AST_CA_START"); // R1

endmodule

// File: tb/test_psram_ctrl.sv
`timescale 1ns/1ps
module test_psram_ctrl;
   localparam int AW = 6;
   localparam int CW = 7;
   localparam int LAT_W = 4;
   localparam int LAT_MIN = 3;
   localparam int NW = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [LAT_W-1:0] cfg_lat = 4'd3;
   logic cfg_force_dbl = 1'b0;
   logic [CW-1:0] cfg_max_words = 7'd20;
   logic req_valid = 1'b0, req_ready, req_read = 1'b0, req_reg = 1'b0, req_linear = 1'b1;
   logic [AW-1:0] req_addr = '0;
   logic [CW-1:0] req_len = '0;
   logic [15:0] wr_data = '0;
   logic [1:0] wr_be = '0;
   logic wr_take, rd_valid, req_err, xfer_done;
   logic [15:0] rd_data;
   logic cs_n, ck, dq_oe, rwds_o, rwds_oe;
   logic [7:0] dq_o;
   logic [7:0] dq_i = 8'h00;
   logic rwds_i = 1'b0;

   int n_chk = 0;
   int n_bad = 0;
   logic [15:0] dev_mem [NW];
   logic [15:0] exp_mem [NW];
   logic [15:0] dev_reg = 16'h0000;
   logic [15:0] exp_reg = 16'h0000;
   int seed = 0;

   always #5 clk = ~clk;

   psram_ctrl #(.AW(AW), .CW(CW), .LAT_W(LAT_W), .LAT_MIN(LAT_MIN), .CSH_CLK(2)) i_psram_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_lat(cfg_lat), .cfg_force_dbl(cfg_force_dbl),
      .cfg_max_words(cfg_max_words), .req_valid(req_valid), .req_ready(req_ready),
      .req_read(req_read), .req_reg(req_reg), .req_linear(req_linear), .req_addr(req_addr),
      .req_len(req_len), .wr_data(wr_data), .wr_be(wr_be), .wr_take(wr_take),
      .rd_data(rd_data), .rd_valid(rd_valid), .req_err(req_err), .xfer_done(xfer_done),
      .psr_cs_n(cs_n), .psr_ck(ck), .psr_dq_o(dq_o), .psr_dq_oe(dq_oe), .psr_dq_i(dq_i),
      .psr_rwds_o(rwds_o), .psr_rwds_oe(rwds_oe), .psr_rwds_i(rwds_i)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [15:0] wd(input int a, input int j);
      return 16'((a + j) * 16'h0125 + seed * 16'h0b07 + 16'h3c);
   endfunction

   function automatic logic [1:0] wbe(input int j);
      return 2'((j + seed) % 4);
   endfunction

   // Chip select high-time monitor (R9)
   int hi_run = 100;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_n && hi_run > 0) begin
            chk(hi_run >= 4, "R9 cs high gap", 64'(hi_run), 64'd4);
            hi_run = 0;
         end else if (cs_n) begin
            hi_run = hi_run + 1;
         end
      end
   end

   task automatic xfer(input bit rd, input bit rg, input bit lin, input int addr, input int len,
                       input bit lat_hi, input int lat, input bit fdbl);
      logic [47:0] ca, eca;
      logic [7:0] hi, lo;
      logic [15:0] w;
      logic mh, ml;
      int t, m, leff, k, rx;
      string lab;
      cfg_lat = 4'(lat);
      cfg_force_dbl = fdbl;
      rwds_i = lat_hi;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_read = rd; req_reg = rg; req_linear = lin;
      req_addr = AW'(addr); req_len = CW'(len);
      wr_data = wd(addr, 0); wr_be = wbe(0);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      ca = '0;
      for (int i = 0; i < 6; i++) begin
         if (i > 0) @(negedge clk);
         chk(!cs_n && dq_oe && (ck == 1'(i % 2)), "R10 ca phase", {cs_n, dq_oe, ck}, {2'b01, 1'(i % 2)});
         ca = {ca[39:0], dq_o};
      end
      eca = {rd, rg, lin, 29'(addr >> 3), 13'd0, 3'(addr & 7)};
      chk(ca == eca, "R1 command word", 64'(ca), 64'(eca));
      m = (lat_hi || fdbl) ? 2 : 1;
      leff = (lat < LAT_MIN) ? LAT_MIN : lat;
      t = (rg && !rd) ? 0 : 2 * leff * m;
      lab = (lat < LAT_MIN) ? "R3 latency floor" : "R2 latency";
      k = 6;
      for (int i = 0; i < t; i++) begin
         @(negedge clk);
         chk(!cs_n && !dq_oe && !rwds_oe && (ck == 1'(k % 2)), "R8 latency idle bus",
             {cs_n, dq_oe, rwds_oe, ck}, {3'b000, 1'(k % 2)});
         k++;
      end
      if (!rd) begin
         for (int j = 0; j < len; j++) begin
            @(negedge clk);
            if (j == 0) chk(dq_oe && wr_take, rg ? "R4 immediate data" : lab, {dq_oe, wr_take}, 2'b11);
            chk(rwds_oe == !rg, "R4 strobe drive", 64'(rwds_oe), 64'(!rg));
            hi = dq_o; mh = rwds_o;
            @(negedge clk);
            lo = dq_o; ml = rwds_o;
            w = wd(addr, j);
            chk({hi, lo} == w, "R5 write bytes", {hi, lo}, w);
            if (!rg) begin
               chk({mh, ml} == ~wbe(j), "R5 write mask", {mh, ml}, ~wbe(j));
               if (!mh) dev_mem[addr + j][15:8] = hi;
               if (!ml) dev_mem[addr + j][7:0] = lo;
               if (wbe(j)[1]) exp_mem[addr + j][15:8] = w[15:8];
               if (wbe(j)[0]) exp_mem[addr + j][7:0] = w[7:0];
            end else begin
               dev_reg = {hi, lo};
               exp_reg = w;
            end
            wr_data = wd(addr, j + 1); wr_be = wbe(j + 1);
         end
         @(negedge clk);
         chk(cs_n && xfer_done && !ck, "R9 end of write", {cs_n, xfer_done, ck}, 3'b110);
      end else begin
         rx = 0;
         for (int j = 0; j < len; j++) begin
            for (int b = 0; b < 2; b++) begin
               @(negedge clk);
               chk(!dq_oe && !rwds_oe && !cs_n, "R8 read undriven", {dq_oe, rwds_oe, cs_n}, 3'b000);
               if (rd_valid) begin
                  w = rg ? exp_reg : exp_mem[addr + rx];
                  chk(rd_data == w, "R6 read word", rd_data, w);
                  rx++;
               end
               w = rg ? dev_reg : dev_mem[addr + j];
               rwds_i = ~rwds_i;
               dq_i = (b == 0) ? w[15:8] : w[7:0];
            end
         end
         @(negedge clk);
         if (rd_valid) begin
            w = rg ? exp_reg : exp_mem[addr + rx];
            chk(rd_data == w, "R6 read word", rd_data, w);
            rx++;
         end
         chk(rx == len, "R6 word count", 64'(rx), 64'(len));
         @(negedge clk);
         chk(cs_n && xfer_done && !ck, "R9 end of read", {cs_n, xfer_done, ck}, 3'b110);
      end
   endtask

   task automatic refuse(input int addr, input int len);
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_read = 1'b0; req_reg = 1'b0; req_addr = AW'(addr); req_len = CW'(len);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_err && cs_n, "R7 refused", {req_err, cs_n}, 2'b11);
      @(negedge clk);
      chk(!req_err && cs_n && req_ready, "R7 stays idle", {req_err, cs_n, req_ready}, 3'b011);
   endtask

   initial begin
      int lats [4] = '{1, 3, 4, 6};
      for (int i = 0; i < NW; i++) begin
         dev_mem[i] = 16'(i * 16'h0303 + 16'h1111);
         exp_mem[i] = dev_mem[i];
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n && !ck && !dq_oe && !rwds_oe && req_ready && !req_err && !rd_valid,
          "R10 reset state", {cs_n, ck, dq_oe, rwds_oe, req_ready}, 5'b10001);
      for (int li = 0; li < 4; li++) begin
         for (int fd = 0; fd < 2; fd++) begin
            for (int lh = 0; lh < 2; lh++) begin
               int a, n;
               seed = li * 4 + fd * 2 + lh;
               a = li * 12 + fd * 6 + lh * 3;
               n = 1 + (li + lh) % 3;
               xfer(1'b0, 1'b0, 1'b1, a, n, 1'(lh), lats[li], 1'(fd));
               xfer(1'b1, 1'b0, 1'b1, a, n, 1'(lh ^ fd), lats[li], 1'(fd));
            end
         end
      end
      seed = 21;
      xfer(1'b0, 1'b1, 1'b1, 0, 1, 1'b1, 4, 1'b0);
      xfer(1'b1, 1'b1, 1'b1, 0, 1, 1'b0, 4, 1'b0);
      xfer(1'b1, 1'b0, 1'b0, 13, 2, 1'b1, 2, 1'b0);
      seed = 30;
      xfer(1'b0, 1'b0, 1'b1, 61, 3, 1'b0, 3, 1'b0);
      xfer(1'b1, 1'b0, 1'b1, 61, 3, 1'b0, 3, 1'b0);
      seed = 33;
      xfer(1'b0, 1'b0, 1'b1, 0, 20, 1'b0, 3, 1'b0);
      xfer(1'b1, 1'b0, 1'b0, 0, 20, 1'b1, 3, 1'b0);
      refuse(0, 0);
      refuse(0, 21);
      refuse(62, 3);
      refuse(63, 2);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule